// File: doc/BRIEF.md
# Metastability Failure Event Counter

This block is the digital back end of a bench that measures how long a flip-flop takes to settle when its setup and hold times are violated. Two comparators watch the output of the flop under test, one against the high logic threshold and one against the low threshold. While that output sits between the two thresholds, the comparator bits disagree. When the output is clearly high or clearly low, they agree. The block waits a programmable number of fast clock cycles after each rising edge of the reference sampling clock. It then captures both comparator bits in the same cycle and calls the sample a failure if the two bits differ.

Each failure produces a one-cycle pulse and adds one to a failure counter. A second counter totals the fast clock cycles spent running. Firmware divides the elapsed count by the failure count to obtain the mean time between failures. The resolution time under test is the programmed delay minus the worst-case clock-to-output delay of the flop. Both counters saturate, and a sticky flag records any event that was lost to saturation. A synchronous clear restarts a measurement.

Top module: `metastab_fail_counter`

## Requirements
- R1: While reset (`rstN` low) is applied, and right after it is released, `failPulse`, `failCount`, `elapsedCount` and `overflowFlag` are all zero.
- R2: The reference input is registered twice. Suppose `refClkIn` is low in cycle k-1, high in cycle k, `runEn` is high, no sample is pending and `delayCfg` = D (1 to 255). Then the indicators are captured at the clock edge that ends cycle k+1+D, and the outcome shows on `failPulse` in cycle k+2+D only.
- R3: A captured sample is a failure exactly when `hiInd` XOR `loInd` is 1. The patterns 1/0 and 0/1 pulse `failPulse`. The patterns 1/1 and 0/0 leave it low.
- R4: Each cycle with `failPulse` high adds exactly one to `failCount`, and the new value is visible in the following cycle.
- R5: A `delayCfg` of 0 disables sampling. A reference edge then produces no pulse and no count.
- R6: A reference rising edge that arrives while a sample is still pending is ignored. Only the first edge produces a sample.
- R7: While `runEn` is low, reference edges are ignored, a pending sample is abandoned, and `elapsedCount` holds its value.
- R8: `elapsedCount` equals the number of cycles in which `runEn` was high and `clrReq` was low since the last clear. Each such cycle is counted at the following edge.
- R9: Both counters stop at all-ones instead of wrapping. An increment requested while a counter is at all-ones sets `overflowFlag`, which stays set until a clear.
- R10: `clrReq` takes priority over every other input. The cycle after it is asserted, both counters and `overflowFlag` are zero and any pending sample is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast measurement clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refClkIn | input | 1 | Reference sampling clock, observed as a level |
| hiInd | input | 1 | Asynchronous indicator: output above the high threshold |
| loInd | input | 1 | Asynchronous indicator: output above the low threshold |
| runEn | input | 1 | Enables sampling and both counters |
| clrReq | input | 1 | Synchronous clear of counters, flag and pending sample |
| delayCfg | input | DLY_W | Sampling delay in fast clock cycles, 0 disables |
| failPulse | output | 1 | One-cycle pulse after a failing sample |
| failCount | output | CNT_W | Saturating failure count |
| elapsedCount | output | CNT_W | Saturating count of running cycles |
| overflowFlag | output | 1 | Sticky flag: an increment was lost to saturation |

## Verification
If the reference input rises in the cycle k in which the bench drives it, the failure pulse is due in cycle k+2+D and the updated failure count in cycle k+3+D. The elapsed count moves one cycle after each running cycle, and a clear shows its effect one cycle after it is driven. The driver stamps every expected value with the exact cycle in which it is due. The monitor compares only at the falling edge of that cycle. It also checks that the pulse is low in the cycles just before and just after that cycle, so a design that is off by one cycle is caught. Any expectation left unchecked at the end of the run counts as a failure.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

  // Strobes handed from control to datapath every cycle.
  typedef struct packed {
    logic sampleStb;   // capture both indicators at the end of this cycle
    logic clearAll;    // zero counters, flag and capture state
    logic runActive;   // running and not clearing: count elapsed time
  } mfcCtrl_t;

endpackage

// File: rtl/mfc_ctrl.sv
module mfc_ctrl #(
  parameter int DLY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refClkIn,
  input  logic              runEn,
  input  logic              clrReq,
  input  logic [DLY_W-1:0]  delayCfg,
  output mfc_pkg::mfcCtrl_t ctrl
);

  localparam logic [DLY_W-1:0] LAST_TICK = DLY_W'(1);

  logic             refReg;
  logic             refPrev;
  logic             refRise;
  logic [DLY_W-1:0] dlyCnt;
  logic             dlyIdle;
  logic             loadNow;

  // Reference input registered, then edge-detected against its delayed copy.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refReg  <= 1'b0;
      refPrev <= 1'b0;
    end else begin
      refReg  <= refClkIn;
      refPrev <= refReg;
    end
  end

  assign refRise = refReg & ~refPrev;
  assign dlyIdle = (dlyCnt == '0);
  assign loadNow = refRise & dlyIdle & runEn & ~clrReq & (delayCfg != '0);

  // Countdown: loaded with delayCfg, strobe fires while it holds 1.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt <= '0;
    end else if (clrReq || !runEn) begin
      dlyCnt <= '0;
    end else if (loadNow) begin
      dlyCnt <= delayCfg;
    end else if (!dlyIdle) begin
      dlyCnt <= dlyCnt - DLY_W'(1);
    end
  end

  always_comb begin
    ctrl.sampleStb = runEn & ~clrReq & (dlyCnt == LAST_TICK);
    ctrl.clearAll  = clrReq;
    ctrl.runActive = runEn & ~clrReq;
  end

endmodule

// File: rtl/mfc_satcounter.sv
module mfc_satcounter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         satHit
);

  localparam logic [W-1:0] MAX_VAL = '1;

  logic atMax;

  assign atMax  = (value == MAX_VAL);
  assign satHit = inc & atMax & ~clr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      value <= '0;
    end else if (clr) begin
      value <= '0;
    end else if (inc && !atMax) begin
      value <= value + W'(1);
    end
  end

endmodule

// File: rtl/mfc_datapath.sv
module mfc_datapath #(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mfc_pkg::mfcCtrl_t ctrl,
  input  logic              hiInd,
  input  logic              loInd,
  output logic              failPulse,
  output logic [CNT_W-1:0]  failCount,
  output logic [CNT_W-1:0]  elapsedCount,
  output logic              overflowFlag
);

  localparam int N_CNT = 2;

  logic             hiCap;
  logic             loCap;
  logic             capValid;
  logic [N_CNT-1:0] incVec;
  logic [N_CNT-1:0] satVec;
  logic [CNT_W-1:0] cntArr [N_CNT];

  // Indicators are only ever touched on the strobe edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCap <= 1'b0;
      loCap <= 1'b0;
    end else if (ctrl.sampleStb) begin
      hiCap <= hiInd;
      loCap <= loInd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValid <= 1'b0;
    end else begin
      capValid <= ctrl.sampleStb & ~ctrl.clearAll;
    end
  end

  assign failPulse = capValid & (hiCap ^ loCap);

  // Index 0 counts failures, index 1 counts running cycles.
  assign incVec = {ctrl.runActive, failPulse};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    mfc_satcounter #(.W(CNT_W)) cnt_i (
      .clk    (clk),
      .rstN   (rstN),
      .clr    (ctrl.clearAll),
      .inc    (incVec[g]),
      .value  (cntArr[g]),
      .satHit (satVec[g])
    );
  end

  assign failCount    = cntArr[0];
  assign elapsedCount = cntArr[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflowFlag <= 1'b0;
    end else if (ctrl.clearAll) begin
      overflowFlag <= 1'b0;
    end else if (|satVec) begin
      overflowFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/metastab_fail_counter.sv
module metastab_fail_counter #(
  parameter int CNT_W = 32,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refClkIn,
  input  logic             hiInd,
  input  logic             loInd,
  input  logic             runEn,
  input  logic             clrReq,
  input  logic [DLY_W-1:0] delayCfg,
  output logic             failPulse,
  output logic [CNT_W-1:0] failCount,
  output logic [CNT_W-1:0] elapsedCount,
  output logic             overflowFlag
);

  mfc_pkg::mfcCtrl_t ctrl;

  mfc_ctrl #(.DLY_W(DLY_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .refClkIn (refClkIn),
    .runEn    (runEn),
    .clrReq   (clrReq),
    .delayCfg (delayCfg),
    .ctrl     (ctrl)
  );

  mfc_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .hiInd        (hiInd),
    .loInd        (loInd),
    .failPulse    (failPulse),
    .failCount    (failCount),
    .elapsedCount (elapsedCount),
    .overflowFlag (overflowFlag)
  );

endmodule

// File: rtl/mfc_checker.sv
module mfc_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             runEn,
  input logic             clrReq,
  input logic             failPulse,
  input logic [CNT_W-1:0] failCount,
  input logic [CNT_W-1:0] elapsedCount,
  input logic             overflowFlag
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  a_r2_pulse_isolated: assert property (@(posedge clk) disable iff (!rstN)
    failPulse |=> !failPulse);

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(clrReq) && failCount != $past(failCount))
      |-> failCount == $past(failCount) + CNT_W'(1));

  a_r4_pulse_counts: assert property (@(posedge clk) disable iff (!rstN)
    (failPulse && !clrReq && failCount != ALL_ONES)
      |=> failCount == $past(failCount) + CNT_W'(1));

  a_r7_elapsed_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !clrReq) |=> elapsedCount == $past(elapsedCount));

  a_r9_sat_hold: assert property (@(posedge clk) disable iff (!rstN)
    (failCount == ALL_ONES && !clrReq) |=> failCount == ALL_ONES);

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflowFlag && !clrReq) |=> overflowFlag);

  a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clrReq |=> (failCount == '0 && elapsedCount == '0 && !overflowFlag));

endmodule

bind metastab_fail_counter mfc_checker #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .runEn        (runEn),
  .clrReq       (clrReq),
  .failPulse    (failPulse),
  .failCount    (failCount),
  .elapsedCount (elapsedCount),
  .overflowFlag (overflowFlag)
);

// File: tb/metastab_fail_counter_tb_top.sv
`timescale 1ns/1ps
module metastab_fail_counter_tb_top;

  localparam int CNT_W = 8;
  localparam int DLY_W = 8;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             refClkIn = 1'b0;
  logic             hiInd = 1'b0;
  logic             loInd = 1'b0;
  logic             runEn = 1'b0;
  logic             clrReq = 1'b0;
  logic [DLY_W-1:0] delayCfg = '0;
  logic             failPulse;
  logic [CNT_W-1:0] failCount;
  logic [CNT_W-1:0] elapsedCount;
  logic             overflowFlag;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int expFail = 0;
  bit finished = 0;

  int    qDue[$];
  int    qSel[$];
  int    qVal[$];
  string qTag[$];

  metastab_fail_counter #(.CNT_W(CNT_W), .DLY_W(DLY_W)) dut_i (
    .clk(clk), .rstN(rstN), .refClkIn(refClkIn), .hiInd(hiInd), .loInd(loInd),
    .runEn(runEn), .clrReq(clrReq), .delayCfg(delayCfg), .failPulse(failPulse),
    .failCount(failCount), .elapsedCount(elapsedCount), .overflowFlag(overflowFlag)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sigVal(int sel);
    case (sel)
      0: return int'(failPulse);
      1: return int'(failCount);
      2: return int'(elapsedCount);
      default: return int'(overflowFlag);
    endcase
  endfunction

  function automatic string sigName(int sel);
    case (sel)
      0: return "failPulse";
      1: return "failCount";
      2: return "elapsedCount";
      default: return "overflowFlag";
    endcase
  endfunction

  // Monitor: compare every expectation due in this cycle at the falling edge.
  always @(negedge clk) begin
    for (int i = qDue.size() - 1; i >= 0; i--) begin
      if (qDue[i] == cyc) begin
        total++;
        if (sigVal(qSel[i]) != qVal[i]) begin
          bad++;
          $display("FAIL %s %s cycle=%0d actual=%0d expected=%0d",
                   qTag[i], sigName(qSel[i]), cyc, sigVal(qSel[i]), qVal[i]);
        end
        qDue.delete(i); qSel.delete(i); qVal.delete(i); qTag.delete(i);
      end
    end
  end

  task automatic push(int due, int sel, int val, string tag);
    qDue.push_back(due); qSel.push_back(sel); qVal.push_back(val); qTag.push_back(tag);
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic doClear();
    clrReq = 1'b1;
    step(1);
    clrReq = 1'b0;
    expFail = 0;
    push(cyc, 1, 0, "R10");
    push(cyc, 2, 0, "R10");
    push(cyc, 3, 0, "R10");
  endtask

  // One reference edge with indicators held; expects pulse at k+2+D only.
  task automatic sampleEvent(int d, bit hi, bit lo, string tag);
    int k;
    k = cyc;
    delayCfg = DLY_W'(d);
    hiInd = hi; loInd = lo;
    refClkIn = 1'b1;
    push(k + 1 + d, 0, 0, tag);
    push(k + 2 + d, 0, int'(hi ^ lo), tag);
    push(k + 3 + d, 0, 0, tag);
    if ((hi ^ lo) && expFail < MAXC) expFail++;
    push(k + 3 + d, 1, expFail, "R4");
    step(1);
    refClkIn = 1'b0;
    step(d + 3);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL all watchdog cycle=%0d actual=running expected=finished", cyc);
    report();
  end

  initial begin
    int k;
    step(2);
    push(cyc, 0, 0, "R1"); push(cyc, 1, 0, "R1");
    push(cyc, 2, 0, "R1"); push(cyc, 3, 0, "R1");
    step(1);
    rstN = 1'b1;
    push(cyc, 1, 0, "R1"); push(cyc, 2, 0, "R1"); push(cyc, 3, 0, "R1");
    step(2);

    // Failure decision and delay timing
    doClear();
    runEn = 1'b1;
    step(1);
    sampleEvent(3, 1'b1, 1'b0, "R3");
    sampleEvent(3, 1'b0, 1'b1, "R3");
    sampleEvent(3, 1'b1, 1'b1, "R3");
    sampleEvent(3, 1'b0, 1'b0, "R3");
    sampleEvent(1, 1'b1, 1'b0, "R2");
    sampleEvent(255, 1'b0, 1'b1, "R2");
    sampleEvent(7, 1'b1, 1'b1, "R2");

    // Delay of zero disables sampling
    k = cyc;
    delayCfg = '0; hiInd = 1'b1; loInd = 1'b0; refClkIn = 1'b1;
    for (int j = 1; j <= 10; j++) push(k + j, 0, 0, "R5");
    push(k + 10, 1, expFail, "R5");
    step(1); refClkIn = 1'b0; step(11);

    // Second edge while a sample is pending
    k = cyc;
    delayCfg = DLY_W'(10); hiInd = 1'b1; loInd = 1'b0; refClkIn = 1'b1;
    push(k + 12, 0, 1, "R6");
    for (int j = 13; j <= 20; j++) push(k + j, 0, 0, "R6");
    expFail++;
    push(k + 20, 1, expFail, "R6");
    step(1); refClkIn = 1'b0; step(3);
    refClkIn = 1'b1; step(1); refClkIn = 1'b0;
    step(20);

    // Elapsed time count, then frozen while not running
    runEn = 1'b0;
    step(1);
    doClear();
    runEn = 1'b1;
    step(20);
    push(cyc, 2, 20, "R8");
    runEn = 1'b0;
    push(cyc + 1, 2, 20, "R7");
    push(cyc + 6, 2, 20, "R7");
    k = cyc;
    delayCfg = DLY_W'(2); hiInd = 1'b1; loInd = 1'b0; refClkIn = 1'b1;
    for (int j = 1; j <= 8; j++) push(k + j, 0, 0, "R7");
    push(k + 8, 1, 0, "R7");
    step(1); refClkIn = 1'b0; step(9);

    // Pending sample abandoned when run drops
    runEn = 1'b1;
    step(1);
    k = cyc;
    delayCfg = DLY_W'(10); refClkIn = 1'b1;
    for (int j = 1; j <= 16; j++) push(k + j, 0, 0, "R7");
    push(k + 16, 1, 0, "R7");
    step(1); refClkIn = 1'b0; step(3);
    runEn = 1'b0; step(2);
    runEn = 1'b1; step(12);

    // Elapsed saturation and overflow, then clear while running
    runEn = 1'b0;
    step(1);
    doClear();
    runEn = 1'b1;
    step(300);
    push(cyc, 2, MAXC, "R9");
    push(cyc, 3, 1, "R9");
    push(cyc, 1, 0, "R9");
    step(1);
    doClear();
    push(cyc + 1, 2, 1, "R8");
    step(2);

    // Pending sample cancelled by clear
    k = cyc;
    delayCfg = DLY_W'(5); hiInd = 1'b0; loInd = 1'b1; refClkIn = 1'b1;
    for (int j = 1; j <= 10; j++) push(k + j, 0, 0, "R10");
    step(1); refClkIn = 1'b0; step(2);
    doClear();
    push(k + 10, 1, 0, "R10");
    step(8);

    // Failure counter saturation
    for (int n = 0; n < 260; n++) sampleEvent(1, 1'b1, 1'b0, "R9");
    push(cyc, 1, MAXC, "R9");
    push(cyc, 3, 1, "R9");
    step(2);
    doClear();
    step(3);

    if (qDue.size() != 0) begin
      total++; bad++;
      $display("FAIL all scoreboard actual=%0d expected=0 pending items", qDue.size());
    end
    report();
  end

endmodule